// File: doc/BRIEF.md
# Double-Precision Shift Unit with Flag Update

This combinational unit carries out a double-precision shift at either 16 or 32 bits. A destination operand and a fill operand are joined into one value of twice the width. That value is shifted left or right, and the part the size of the destination is kept as the result. The bits that enter the result therefore come from the fill operand and not from zeros.

Alongside the result, the unit produces updated status flags: carry, overflow, auxiliary carry, zero, sign and parity. It also produces a write-enable that tells the surrounding datapath whether the destination should be written back.

The shift count is taken modulo 32. A count of zero leaves everything unchanged. At 16-bit width, counts above 16 wrap cyclically through the joined 32-bit value. Decoding, register-file access and memory access belong to the surrounding core.

Top module: `dbl_shift_flags`

## Requirements
- R1: Only bits 4:0 of `cnt_i` form the effective count; bits 7:5 have no effect on any output.
- R2: With an effective count of zero:
  - `wr_en_o` is 0.
  - Every flag output equals its matching flag input.
  - `res_o` equals the destination at the selected width, with bits 31:16 zero at 16-bit width.
- R3: Left form at 32-bit width (`wide_i`=1, `dir_right_i`=0): `res_o` is bits 63:32 of {dst, src} shifted left by the count.
- R4: Right form at 32-bit width (`wide_i`=1, `dir_right_i`=1): `res_o` is bits 31:0 of {src, dst} shifted right by the count.
- R5: Left form at 16-bit width:
  - `res_o[15:0]` is bits 31:16 of the 32-bit value {dst[15:0], src[15:0]} rotated left by the count, so counts above 16 wrap cyclically.
  - `res_o[31:16]` is 0.
- R6: Right form at 16-bit width:
  - `res_o[15:0]` is bits 15:0 of {src[15:0], dst[15:0]} rotated right by the count.
  - `res_o[31:16]` is 0.
- R7: With a nonzero count, carry is the last bit moved out:
  - for the left form, bit (2·N − count) of the joined value;
  - for the right form, bit (count − 1) of the joined value;
  - N is 16 or 32.
- R8: With a count of exactly 1, overflow is the top bit (bit N−1) of destination XOR result. For any other nonzero count, overflow keeps `of_i`.
- R9: With a nonzero count, auxiliary carry is 0.
- R10: With a nonzero count, zero is 1 exactly when the N-bit result is 0, and sign is result bit N−1.
- R11: With a nonzero count, parity is 1 when `res_o[7:0]` holds an even number of ones.
- R12: `wr_en_o` is 1 whenever the effective count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 32 | Destination operand (low 16 bits used at 16-bit width) |
| src_i | input | 32 | Fill operand supplying shifted-in bits |
| cnt_i | input | 8 | Raw shift count |
| dir_right_i | input | 1 | 1 selects the right form, 0 the left form |
| wide_i | input | 1 | 1 selects 32-bit width, 0 selects 16-bit width |
| cf_i | input | 1 | Incoming carry flag |
| of_i | input | 1 | Incoming overflow flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| zf_i | input | 1 | Incoming zero flag |
| sf_i | input | 1 | Incoming sign flag |
| pf_i | input | 1 | Incoming parity flag |
| res_o | output | 32 | Shift result |
| cf_o | output | 1 | Updated carry flag |
| of_o | output | 1 | Updated overflow flag |
| af_o | output | 1 | Updated auxiliary-carry flag |
| zf_o | output | 1 | Updated zero flag |
| sf_o | output | 1 | Updated sign flag |
| pf_o | output | 1 | Updated parity flag |
| wr_en_o | output | 1 | Destination write-back enable |

## Verification
The bench sweeps every masked count from 0 to 31, in both directions and at both widths, over operand patterns chosen so that each bit position is distinct. It compares every output against a bit-serial reference.

At 16-bit width, counts from 17 to 31 expose a unit that zero-fills instead of wrapping through the joined value. Counts of 16 and 31 expose off-by-one errors in carry selection, which would show up as a wrong carry. A unit that truncated the destination before joining would lose the upper-half bits and return wrong results for left shifts. Raising the upper count bits catches a mask that is too wide. Count 0 catches a unit that writes or disturbs flags when it should not, and count 2 catches overflow being recomputed when it should be held.

// File: rtl/dbl_shift_flags.sv
module dbl_shift_flags (
  input  logic [31:0] dst_i,
  input  logic [31:0] src_i,
  input  logic [7:0]  cnt_i,
  input  logic        dir_right_i,
  input  logic        wide_i,
  input  logic        cf_i,
  input  logic        of_i,
  input  logic        af_i,
  input  logic        zf_i,
  input  logic        sf_i,
  input  logic        pf_i,
  output logic [31:0] res_o,
  output logic        cf_o,
  output logic        of_o,
  output logic        af_o,
  output logic        zf_o,
  output logic        sf_o,
  output logic        pf_o,
  output logic        wr_en_o
);

  logic [4:0]  m;
  logic [5:0]  ms;
  logic [31:0] cat_l16, cat_r16, rot_l16, rot_r16;
  logic [63:0] cat_l32, cat_r32;
  logic [31:0] res_l32, res_r32;
  logic [31:0] shifted;
  logic        carry, msb;
  logic        unused_bits;

  assign m  = cnt_i[4:0];
  assign ms = {1'b0, m};

  assign cat_l32 = {dst_i, src_i};
  assign cat_r32 = {src_i, dst_i};
  assign cat_l16 = {dst_i[15:0], src_i[15:0]};
  assign cat_r16 = {src_i[15:0], dst_i[15:0]};

  assign res_l32 = (dst_i << ms) | (src_i >> (6'd32 - ms));
  assign res_r32 = (dst_i >> ms) | (src_i << (6'd32 - ms));
  assign rot_l16 = (cat_l16 << ms) | (cat_l16 >> (6'd32 - ms));
  assign rot_r16 = (cat_r16 >> ms) | (cat_r16 << (6'd32 - ms));

  assign unused_bits = ^{rot_l16[15:0], rot_r16[31:16]};

  always_comb begin
    case ({wide_i, dir_right_i})
      2'b00: begin
        shifted = {16'h0, rot_l16[31:16]};
        carry   = cat_l16[5'(5'd0 - m)];
      end
      2'b01: begin
        shifted = {16'h0, rot_r16[15:0]};
        carry   = cat_r16[5'(m - 5'd1)];
      end
      2'b10: begin
        shifted = res_l32;
        carry   = cat_l32[6'(6'd0 - ms)];
      end
      default: begin
        shifted = res_r32;
        carry   = cat_r32[6'(ms - 6'd1)];
      end
    endcase
  end

  assign msb = wide_i ? shifted[31] : shifted[15];

  always_comb begin
    if (m == 5'd0) begin
      wr_en_o = 1'b0;
      res_o   = wide_i ? dst_i : {16'h0, dst_i[15:0]};
      cf_o    = cf_i;
      of_o    = of_i;
      af_o    = af_i;
      zf_o    = zf_i;
      sf_o    = sf_i;
      pf_o    = pf_i;
    end else begin
      wr_en_o = 1'b1;
      res_o   = shifted;
      cf_o    = carry;
      of_o    = (m == 5'd1) ? ((wide_i ? dst_i[31] : dst_i[15]) ^ msb) : of_i;
      af_o    = 1'b0;
      zf_o    = (shifted == 32'h0);
      sf_o    = msb;
      pf_o    = ~^shifted[7:0];
    end
  end

endmodule

// File: rtl/dbl_shift_flags_chk.sv
module dbl_shift_flags_chk (
  input logic [31:0] dst_i,
  input logic [7:0]  cnt_i,
  input logic        wide_i,
  input logic        cf_i,
  input logic        of_i,
  input logic        af_i,
  input logic        zf_i,
  input logic        sf_i,
  input logic        pf_i,
  input logic [31:0] res_o,
  input logic        cf_o,
  input logic        of_o,
  input logic        af_o,
  input logic        zf_o,
  input logic        sf_o,
  input logic        pf_o,
  input logic        wr_en_o
);

  logic known;
  assign known = !$isunknown({dst_i, cnt_i, wide_i, cf_i, of_i, af_i, zf_i, sf_i, pf_i});

  always_comb begin
    if (known) begin
      a_r2_zero_count_holds: assert (cnt_i[4:0] != 5'd0 ||
        (!wr_en_o && cf_o == cf_i && of_o == of_i && af_o == af_i &&
         zf_o == zf_i && sf_o == sf_i && pf_o == pf_i));
      a_r12_write_on_count: assert (cnt_i[4:0] == 5'd0 || wr_en_o);
      a_r9_aux_cleared: assert (!wr_en_o || !af_o);
      a_r8_overflow_held: assert (!wr_en_o || cnt_i[4:0] == 5'd1 || of_o == of_i);
      a_r5_narrow_upper_zero: assert (wide_i || res_o[31:16] == 16'h0);
      a_r11_low_byte_parity: assert (!wr_en_o || pf_o == ~^res_o[7:0]);
      a_r10_sign_bit: assert (!wr_en_o || sf_o == (wide_i ? res_o[31] : res_o[15]));
    end
  end

endmodule

bind dbl_shift_flags dbl_shift_flags_chk u_chk (
  .dst_i(dst_i), .cnt_i(cnt_i), .wide_i(wide_i),
  .cf_i(cf_i), .of_i(of_i), .af_i(af_i), .zf_i(zf_i), .sf_i(sf_i), .pf_i(pf_i),
  .res_o(res_o), .cf_o(cf_o), .of_o(of_o), .af_o(af_o), .zf_o(zf_o),
  .sf_o(sf_o), .pf_o(pf_o), .wr_en_o(wr_en_o)
);

// File: tb/dbl_shift_flags_tb.sv
`timescale 1ns/1ps
module dbl_shift_flags_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] dst, src, res;
  logic [7:0]  cnt;
  logic        dir_r, wide;
  logic        cfi, ofi, afi, zfi, sfi, pfi;
  logic        cfo, ofo, afo, zfo, sfo, pfo, wr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  dbl_shift_flags u_dut (
    .dst_i(dst), .src_i(src), .cnt_i(cnt), .dir_right_i(dir_r), .wide_i(wide),
    .cf_i(cfi), .of_i(ofi), .af_i(afi), .zf_i(zfi), .sf_i(sfi), .pf_i(pfi),
    .res_o(res), .cf_o(cfo), .of_o(ofo), .af_o(afo), .zf_o(zfo), .sf_o(sfo),
    .pf_o(pfo), .wr_en_o(wr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (dst=%h src=%h cnt=%0d right=%0b wide=%0b)",
               tag, act, exp, dst, src, cnt, dir_r, wide);
    end
  endtask

  task automatic run_case(input logic [31:0] d, input logic [31:0] s, input logic [7:0] c,
                          input logic r, input logic w, input logic [5:0] fl);
    int n, k;
    logic [63:0] cat;
    logic [31:0] e_res;
    logic e_cf, e_of, e_msb, b;
    string rtag;
    dst = d; src = s; cnt = c; dir_r = r; wide = w;
    {cfi, ofi, afi, zfi, sfi, pfi} = fl;
    n = w ? 32 : 16;
    k = int'(c) % 32;
    e_cf = fl[5];
    if (r) cat = w ? {s, d} : {32'h0, s[15:0], d[15:0]};
    else   cat = w ? {d, s} : {32'h0, d[15:0], s[15:0]};
    for (int i = 0; i < k; i++) begin
      if (r) begin
        b = cat[0]; e_cf = b;
        cat = cat >> 1;
        cat[2*n-1] = b;
      end else begin
        b = cat[2*n-1]; e_cf = b;
        cat = cat << 1;
        cat[0] = b;
        if (!w) cat[63:32] = 32'h0;
      end
    end
    if (k == 0) e_res = w ? d : {16'h0, d[15:0]};
    else if (r) e_res = w ? cat[31:0] : {16'h0, cat[15:0]};
    else        e_res = w ? cat[63:32] : {16'h0, cat[31:16]};
    #1;
    if (c[7:5] != 3'd0) rtag = "R1 masked count";
    else if (k == 0) rtag = "R2 hold result";
    else if (w && !r) rtag = "R3 left32";
    else if (w && r)  rtag = "R4 right32";
    else if (!r)      rtag = "R5 left16";
    else              rtag = "R6 right16";
    chk(rtag, res, e_res);
    if (k == 0) begin
      chk("R2 no write", {31'h0, wr}, 32'h0);
      chk("R2 flags kept", {26'h0, cfo, ofo, afo, zfo, sfo, pfo}, {26'h0, fl});
    end else begin
      e_msb = w ? e_res[31] : e_res[15];
      e_of  = (k == 1) ? ((w ? d[31] : d[15]) ^ e_msb) : fl[4];
      chk("R12 write", {31'h0, wr}, 32'h1);
      chk("R7 carry", {31'h0, cfo}, {31'h0, e_cf});
      chk("R8 overflow", {31'h0, ofo}, {31'h0, e_of});
      chk("R9 aux clear", {31'h0, afo}, 32'h0);
      chk("R10 zero", {31'h0, zfo}, {31'h0, e_res == 32'h0});
      chk("R10 sign", {31'h0, sfo}, {31'h0, e_msb});
      chk("R11 parity", {31'h0, pfo}, {31'h0, ~^e_res[7:0]});
    end
    #1;
  endtask

  logic [31:0] pat_d [8];
  logic [31:0] pat_s [8];

  initial begin
    pat_d[0] = 32'h8000_0001; pat_s[0] = 32'h0000_0000;
    pat_d[1] = 32'h1234_5678; pat_s[1] = 32'h9ABC_DEF0;
    pat_d[2] = 32'hFFFF_FFFF; pat_s[2] = 32'h0000_0000;
    pat_d[3] = 32'h0000_0000; pat_s[3] = 32'hFFFF_FFFF;
    pat_d[4] = 32'hA5A5_5A5A; pat_s[4] = 32'h0F0F_F0F0;
    pat_d[5] = 32'hDEAD_4000; pat_s[5] = 32'h0001_8001;
    pat_d[6] = 32'h0000_0000; pat_s[6] = 32'h0000_0000;
    pat_d[7] = 32'h7FFF_C003; pat_s[7] = 32'h8421_1248;
    dst = 32'h0; src = 32'h0; cnt = 8'h0; dir_r = 1'b0; wide = 1'b0;
    {cfi, ofi, afi, zfi, sfi, pfi} = 6'b101011;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: idle state right after reset with zero count
    #1;
    chk("R2 reset no write", {31'h0, wr}, 32'h0);
    chk("R2 reset flags", {26'h0, cfo, ofo, afo, zfo, sfo, pfo}, 32'h2B);
    for (int p = 0; p < 8; p++)
      for (int w = 0; w < 2; w++)
        for (int r = 0; r < 2; r++)
          for (int c = 0; c < 32; c++)
            run_case(pat_d[p], pat_s[p], 8'(c), r[0], w[0], 6'(p * 9 + c));
    // R1: upper count bits must have no effect
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 32; c += 5)
        run_case(pat_d[p], pat_s[p], 8'(c + 32 * (p % 7 + 1)), p[0], p[1], 6'(p * 5 + c));
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      if (rst_n) cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule